// File: doc/BRIEF.md
# Conversion Mode and One-Shot Sequencer

This block decides when the temperature converter of a sensor front end starts a conversion. A register write carries three things at once: a shutdown flag, a single-conversion trigger and a two-bit rate code. The converter is outside the block. It receives a one-cycle start pulse and answers with a one-cycle done strobe once its result is ready. The length of a conversion is set by the converter, which is modelled in the testbench with a short cycle count.

With shutdown clear, the sequencer runs without pause. It issues a start once every programmed period, or one cycle after the previous conversion's done if that conversion took longer than the period. With shutdown set, it stays idle. A trigger written while idle in shutdown launches exactly one conversion, and the block goes idle again by itself when that conversion ends. The trigger bit reads back as 0 while that single conversion is running and as 1 after it has finished. A fixed two-bit resolution code reads back as binary 11, which selects 12-bit results.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the block is in continuous mode, with the trigger readback at 0 and the rate code at 2. No start is issued during reset. The first start pulse appears in the first cycle after reset is released.
- R2: In continuous mode, when each conversion finishes within the period, consecutive start pulses are exactly BASE_CYCLES << rate cycles apart, for rate codes 0 to 3.
- R3: In continuous mode, when a conversion outlasts the period, the next start is issued on the clock edge after the done strobe is taken. The start is therefore seen two cycles after the done.
- R4: Setting shutdown while a continuous conversion is in flight lets that conversion finish, and no further start follows.
- R5: In shutdown with no conversion running, a write with shutdown=1 and trigger=1 produces exactly one start pulse.
- R6: The trigger readback is 0 from the clock edge that accepts the trigger until that conversion's done is taken.
- R7: After the single conversion's done, the trigger readback is 1 and the block issues no further starts.
- R8: A trigger written while in continuous mode has no effect: the trigger readback and the start spacing are unchanged.
- R9: A trigger written while a conversion is running is dropped, and no second conversion is queued.
- R10: The resolution output always reads binary 11, before and after any write.
- R11: A done strobe that arrives while no conversion is running causes no start and leaves the trigger readback unchanged.
- R12: Clearing shutdown while idle produces a start pulse in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_shutdown | input | 1 | Shutdown flag written on wr_en |
| wr_oneshot | input | 1 | Single-conversion trigger written on wr_en |
| wr_rate | input | 2 | Rate code written on wr_en; period is BASE_CYCLES << code |
| conv_done | input | 1 | One-cycle done strobe from the converter |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| oneshot_status | output | 1 | Trigger readback: 0 while a single conversion runs, 1 once it finished |
| resolution | output | 2 | Read-only resolution code, fixed at 11 |

## Verification
The bench drives the sequencer against a converter model whose conversion time can be made shorter or longer than the period. It covers both spacing rules. A design that counted the period from the done strobe instead of from the start, or that missed a late done, would show the wrong start intervals. Shutdown is set in the middle of a conversion: a design that cut off the conversion in flight would lose its done, and a design that ignored the flag would keep issuing starts. Triggers are written in continuous mode, written twice during one conversion, and followed by a stray done. A design that queued or double-counted these would produce an extra start or a wrong trigger readback.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int RATE_STEPS = 4;
    localparam logic [1:0] RATE_RESET = 2'd2;
    localparam logic [1:0] RES_CODE = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_GAP  = 2'd2
    } cs_state_e;

    typedef struct packed {
        cs_state_e   state;
        logic        shut;
        logic        single;
        logic        single_done;
        logic        start;
        logic [1:0]  rate;
    } cs_regs_t;

    localparam cs_regs_t CS_RESET = '{
        state:       ST_IDLE,
        shut:        1'b0,
        single:      1'b0,
        single_done: 1'b0,
        start:       1'b0,
        rate:        RATE_RESET
    };

endpackage

// File: rtl/cs_rate_timer.sv
module cs_rate_timer
    import conv_seq_pkg::*;
#(
    parameter int BASE_CYCLES = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] rate_sel,
    output logic       elapsed
);

    localparam int MAX_PERIOD = BASE_CYCLES << (RATE_STEPS - 1);
    localparam int CW = $clog2(MAX_PERIOD + 1);
    localparam logic [CW-1:0] LIMIT_MAX = CW'(MAX_PERIOD - 1);

    logic [CW-1:0] limit_tbl [RATE_STEPS];
    logic [CW-1:0] cnt_d, cnt_q;

    // One compare limit per rate code: period minus one, counted from the start edge.
    for (genvar g = 0; g < RATE_STEPS; g++) begin : g_limit
        assign limit_tbl[g] = CW'((BASE_CYCLES << g) - 1);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q < LIMIT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign elapsed = (cnt_q >= limit_tbl[rate_sel]);

    // R2: the counter holds at its ceiling until a new start restarts it
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q == LIMIT_MAX) |=> (cnt_q == LIMIT_MAX));

    // R2: a restart begins a fresh period, which cannot be elapsed one cycle later for periods above one
    p_restart_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && BASE_CYCLES > 1) |=> !elapsed);

endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
    import conv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_shut,
    input  logic       wr_single,
    input  logic [1:0] wr_rate,
    input  logic       conv_done,
    input  logic       elapsed,
    output logic       timer_restart,
    output logic       conv_start,
    output logic       single_status,
    output logic [1:0] rate_sel
);

    cs_regs_t r_d, r_q;
    logic     accept;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        accept    = wr_en && wr_single && wr_shut && r_q.shut && (r_q.state == ST_IDLE);

        if (wr_en) begin
            r_d.shut = wr_shut;
            r_d.rate = wr_rate;
        end

        case (r_q.state)
            ST_IDLE: begin
                if (!r_q.shut) begin
                    r_d.state  = ST_CONV;
                    r_d.start  = 1'b1;
                    r_d.single = 1'b0;
                end else if (accept) begin
                    r_d.state       = ST_CONV;
                    r_d.start       = 1'b1;
                    r_d.single      = 1'b1;
                    r_d.single_done = 1'b0;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    r_d.state  = (r_q.shut || r_q.single) ? ST_IDLE : ST_GAP;
                    r_d.single = 1'b0;
                    if (r_q.single) begin
                        r_d.single_done = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (r_q.shut) begin
                    r_d.state = ST_IDLE;
                end else if (elapsed) begin
                    r_d.state  = ST_CONV;
                    r_d.start  = 1'b1;
                    r_d.single = 1'b0;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign timer_restart = r_d.start;
    assign conv_start    = r_q.start;
    assign single_status = r_q.single_done;
    assign rate_sel      = r_q.rate;

    // R9: no new start while a conversion is still waiting for its done
    p_no_start_in_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CONV) |=> !r_q.start);

    // R6: readback stays low for the whole single conversion
    p_single_low_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CONV && r_q.single) |-> !r_q.single_done);

    // R7: done of the single conversion sets the readback and returns to idle
    p_single_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CONV && r_q.single && conv_done)
            |=> (r_q.single_done && r_q.state == ST_IDLE && !r_q.start));

    // R4: in shutdown a start only follows an accepted trigger
    p_shut_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.start |-> $past(accept || !r_q.shut));

    // R2: no start before the period has elapsed
    p_gap_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_GAP && !elapsed) |=> !r_q.start);

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int BASE_CYCLES = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_shutdown,
    input  logic       wr_oneshot,
    input  logic [1:0] wr_rate,
    input  logic       conv_done,
    output logic       conv_start,
    output logic       oneshot_status,
    output logic [1:0] resolution
);

    logic       restart;
    logic       elapsed;
    logic [1:0] rate_sel;

    cs_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_shut       (wr_shutdown),
        .wr_single     (wr_oneshot),
        .wr_rate       (wr_rate),
        .conv_done     (conv_done),
        .elapsed       (elapsed),
        .timer_restart (restart),
        .conv_start    (conv_start),
        .single_status (oneshot_status),
        .rate_sel      (rate_sel)
    );

    cs_rate_timer #(
        .BASE_CYCLES (BASE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .rate_sel (rate_sel),
        .elapsed  (elapsed)
    );

    assign resolution = RES_CODE;

endmodule

// File: tb/conv_sequencer_tb_top.sv
module conv_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 8;

    // rate code, expected start spacing in cycles (BASE << code)
    localparam int VEC [4][2] = '{'{0, 8}, '{1, 16}, '{2, 32}, '{3, 64}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_shutdown = 1'b0;
    logic       wr_oneshot = 1'b0;
    logic [1:0] wr_rate = 2'd2;
    logic       model_done = 1'b0;
    logic       inj_done = 1'b0;
    logic       conv_done;
    logic       conv_start;
    logic       oneshot_status;
    logic [1:0] resolution;

    int checks = 0;
    int errors = 0;
    int model_delay = 5;
    int remain = 0;
    int cyc = 0;
    int start_cnt = 0;
    int done_cnt = 0;
    int last_start = 0;
    int prev_start = 0;
    int last_done = 0;

    assign conv_done = model_done | inj_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    conv_sequencer #(.BASE_CYCLES(BASE)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_shutdown    (wr_shutdown),
        .wr_oneshot     (wr_oneshot),
        .wr_rate        (wr_rate),
        .conv_done      (conv_done),
        .conv_start     (conv_start),
        .oneshot_status (oneshot_status),
        .resolution     (resolution)
    );

    // converter model: done strobe a fixed number of cycles after each start
    always @(posedge clk) begin
        if (!rst_n) begin
            remain     <= 0;
            model_done <= 1'b0;
        end else begin
            model_done <= 1'b0;
            if (conv_start) begin
                remain <= model_delay;
            end else if (remain == 1) begin
                model_done <= 1'b1;
                remain     <= 0;
            end else if (remain > 1) begin
                remain <= remain - 1;
            end
        end
    end

    // event monitor
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (conv_start) begin
            prev_start <= last_start;
            last_start <= cyc;
            start_cnt  <= start_cnt + 1;
        end
        if (conv_done) begin
            last_done <= cyc;
            done_cnt  <= done_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sd, input logic os, input logic [1:0] rt);
        wr_en       = 1'b1;
        wr_shutdown = sd;
        wr_oneshot  = os;
        wr_rate     = rt;
        @(posedge clk);
        @(negedge clk);
        wr_en      = 1'b0;
        wr_oneshot = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        int d0;
        repeat (3) @(negedge clk);
        chk("R1 start low in reset", int'(conv_start), 0);
        chk("R1 oneshot status at reset", int'(oneshot_status), 0);
        chk("R10 resolution at reset", int'(resolution), 3);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 first start after reset", int'(conv_start), 1);

        // R2: start spacing per rate code
        for (int i = 0; i < 4; i++) begin
            wr(1'b0, 1'b0, 2'(VEC[i][0]));
            n = start_cnt;
            wait (start_cnt >= n + 3);
            @(negedge clk);
            chk($sformatf("R2 period rate %0d", VEC[i][0]), last_start - prev_start, VEC[i][1]);
        end

        // R8: trigger in continuous mode has no effect
        wr(1'b0, 1'b0, 2'd0);
        n = start_cnt;
        wait (start_cnt >= n + 1);
        @(negedge clk);
        wr(1'b0, 1'b1, 2'd0);
        n = start_cnt;
        wait (start_cnt >= n + 3);
        @(negedge clk);
        chk("R8 spacing unchanged", last_start - prev_start, 8);
        chk("R8 status unchanged", int'(oneshot_status), 0);

        // R3: conversion longer than the period
        model_delay = 20;
        n = start_cnt;
        wait (start_cnt >= n + 3);
        @(negedge clk);
        chk("R3 start two cycles after done", last_start - last_done, 2);
        model_delay = 5;
        n = start_cnt;
        wait (start_cnt >= n + 2);

        // R4: shutdown during a conversion
        n = start_cnt;
        wait (start_cnt >= n + 1);
        @(negedge clk);
        d0 = done_cnt;
        n = start_cnt;
        wr(1'b1, 1'b0, 2'd0);
        repeat (80) @(negedge clk);
        chk("R4 conversion in flight finished", done_cnt, d0 + 1);
        chk("R4 no start after shutdown", start_cnt, n);

        // R5, R6, R7: single conversion
        n = start_cnt;
        wr(1'b1, 1'b1, 2'd0);
        chk("R6 status low while running", int'(oneshot_status), 0);
        repeat (60) @(negedge clk);
        chk("R5 exactly one start", start_cnt, n + 1);
        chk("R7 status high after done", int'(oneshot_status), 1);

        // R9: trigger during a running conversion is dropped
        n = start_cnt;
        wr(1'b1, 1'b1, 2'd0);
        @(negedge clk);
        wr(1'b1, 1'b1, 2'd0);
        chk("R9 status low during conversion", int'(oneshot_status), 0);
        repeat (60) @(negedge clk);
        chk("R9 no queued conversion", start_cnt, n + 1);
        chk("R7 status high again", int'(oneshot_status), 1);

        // R11: stray done while idle
        n = start_cnt;
        inj_done = 1'b1;
        @(negedge clk);
        inj_done = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11 no start from stray done", start_cnt, n);
        chk("R11 status unchanged", int'(oneshot_status), 1);

        // R12: leave shutdown
        wr(1'b0, 1'b0, 2'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R12 start after leaving shutdown", int'(conv_start), 1);
        chk("R10 resolution after writes", int'(resolution), 3);

        // R1: reset in the middle of operation
        repeat (10) @(negedge clk);
        wr(1'b1, 1'b0, 2'd1);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 status cleared by reset", int'(oneshot_status), 0);
        chk("R1 no start in reset", int'(conv_start), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 continuous after reset", int'(conv_start), 1);
        n = start_cnt;
        wait (start_cnt >= n + 3);
        @(negedge clk);
        chk("R1 reset rate code 2", last_start - prev_start, 32);

        finish_run();
    end

endmodule